// File: doc/BRIEF.md
# Time-Redundant Linear Systolic Matrix-Vector Multiplier

This block computes y = A·x on a linear chain of processing elements, one element per row of A. The vector x enters the first element and walks down the chain one element per period, while each matrix column arrives at the same time and is skewed inside the block so that row k meets x[j] exactly k periods after it entered. The schedule has a period of three cycles. Every element owns one multiply-accumulate unit and uses it in all three cycles of a period. It runs the same step three times, once into each of three private accumulators.

When an element has absorbed the last column of a job, its three copies go to a shared majority voter. The voter emits one result word per row with a valid strobe. A test-only fault port can flip bits in the product that feeds any chosen set of copies on any chosen set of rows. This shows how a single corrupted copy is masked, and how an uncorrectable case is reported when all three copies differ. A host streams one column and one vector element per period, and results appear in row order.

Top module: `tmr_systolic_mv`

## Requirements
- R1: While reset is asserted and in the first cycle after it, resValid and inReady are low.
- R2: inReady is high in exactly one cycle out of every three, and a beat is taken only in a cycle where inValid and inReady are both high.
- R3: With no fault active, the result for row k equals the sum over j of A[k][j]·x[j] (unsigned, modulo 2^ACCW), where column j arrives as inCol with A[k][j] at bits k·W upward.
- R4: For a job, the result for row k has resIdx = k and is shown for exactly one cycle. That cycle lies 3·(k+1) cycles after the clock edge that took the job's last beat, so rows come out in ascending order.
- R5: A fault that corrupts one copy of a row, with that copy being 0, 1 or 2, leaves resData correct and resUncorr low.
- R6: Faults that each corrupt a single copy on several different rows in the same job are all masked.
- R7: When a row's three copies all differ, resData is copy 0 and resUncorr is high. resUncorr is never high without resValid.
- R8: inValid asserted in cycles where inReady is low has no effect on any result.
- R9: A job may start in the period right after the previous job's last beat, with no idle period, and both jobs give correct results.
- R10: With faultEn low, the row, copy and mask selections have no effect on the results.
- R11: A corrupted copy c on row k replaces each product p of that copy with p XOR (faultMask shifted left by c bits), truncated to ACCW bits. When two copies of the same row are corrupted, all three copies generally differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A beat (column plus vector element) is offered |
| inReady | output | 1 | Beat slot of the current period; high one cycle in three |
| inVec | input | W | Vector element x[j] |
| inCol | input | PES·W | Column j of A; row k in bits k·W upward |
| faultEn | input | 1 | Enables fault injection |
| faultRows | input | PES | Rows whose copies are corrupted |
| faultCopies | input | 3 | Copies (bit c = copy c) that are corrupted |
| faultMask | input | ACCW | XOR pattern applied to the product, shifted left by the copy number |
| resValid | output | 1 | A voted result is present |
| resIdx | output | max(1,clog2(PES)) | Row of the result |
| resData | output | ACCW | Voted result |
| resUncorr | output | 1 | All three copies disagreed |

## Verification
Two functions can fall on the same clock edge. One row casts its vote on its final sums while, with back-to-back jobs, the first element accumulates a fresh first beat into the same copy slot. The bench provokes this by issuing jobs with no idle period between them, including one where faults corrupt one copy on several rows at once. It also keeps inValid high in off-slot cycles during those jobs. A behavioural model predicts, from the accept cycle of each job's last beat, the exact cycle, row, voted value and uncorrectable flag of every result. Every clock is compared against that model, so a result lost, shifted or overwritten by the next job's start shows up as a mismatch.

// File: rtl/tmr_mv_pkg.sv
package tmr_mv_pkg;

  localparam logic [1:0] PH_COPY0 = 2'd0;
  localparam logic [1:0] PH_COPY2 = 2'd2;

  // Strobes from the period controller to the datapath.
  typedef struct packed {
    logic       shift;   // operands advance one element at this edge
    logic       accept;  // a beat is taken at this edge
    logic       first;   // accepted beat is column 0 of a job
    logic       last;    // accepted beat is the final column of a job
    logic [1:0] phase;   // copy tag of the current cycle
  } tmr_strobe_t;

endpackage

// File: rtl/tmr_mv_ctrl.sv
module tmr_mv_ctrl
  import tmr_mv_pkg::*;
#(
  parameter int COLS = 6,
  localparam int CBW = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output logic        inReady,
  output tmr_strobe_t strb
);

  logic [1:0]     phase;
  logic [CBW-1:0] beatCnt;
  logic           takeBeat;
  logic           lastBeat;

  assign inReady  = (phase == PH_COPY2);
  assign takeBeat = inReady && inValid;
  assign lastBeat = (beatCnt == CBW'(COLS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_COPY0;
      beatCnt <= '0;
    end else begin
      phase <= (phase == PH_COPY2) ? PH_COPY0 : phase + 2'd1;
      if (takeBeat) begin
        beatCnt <= lastBeat ? '0 : beatCnt + CBW'(1);
      end
    end
  end

  always_comb begin
    strb.shift  = inReady;
    strb.accept = takeBeat;
    strb.first  = takeBeat && (beatCnt == '0);
    strb.last   = takeBeat && lastBeat;
    strb.phase  = phase;
  end

endmodule

// File: rtl/tmr_mv_datapath.sv
module tmr_mv_datapath
  import tmr_mv_pkg::*;
#(
  parameter int PES  = 4,
  parameter int W    = 8,
  parameter int ACCW = 20,
  localparam int PEW = (PES > 1) ? $clog2(PES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmr_strobe_t       strb,
  input  logic [W-1:0]      inVec,
  input  logic [PES*W-1:0]  inCol,
  input  logic              faultEn,
  input  logic [PES-1:0]    faultRows,
  input  logic [2:0]        faultCopies,
  input  logic [ACCW-1:0]   faultMask,
  output logic              resValid,
  output logic [PEW-1:0]    resIdx,
  output logic [ACCW-1:0]   resData,
  output logic              resUncorr
);

  // Operand chain: stage k holds the beat that row k works on this period.
  logic [W-1:0]    xStage [PES];
  logic [PES-1:0]  valStage;
  logic [PES-1:0]  firstStage;
  logic [PES-1:0]  lastStage;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      valStage   <= '0;
      firstStage <= '0;
      lastStage  <= '0;
      for (int k = 0; k < PES; k++) xStage[k] <= '0;
    end else if (strb.shift) begin
      xStage[0]     <= inVec;
      valStage[0]   <= strb.accept;
      firstStage[0] <= strb.first;
      lastStage[0]  <= strb.last;
      for (int k = 1; k < PES; k++) begin
        xStage[k]     <= xStage[k-1];
        valStage[k]   <= valStage[k-1];
        firstStage[k] <= firstStage[k-1];
        lastStage[k]  <= lastStage[k-1];
      end
    end
  end

  logic [2:0] copyHot;
  logic [2:0] hitCopy;
  assign copyHot = 3'b001 << strb.phase;
  assign hitCopy = faultEn ? (copyHot & faultCopies) : 3'b000;

  logic [ACCW-1:0] copy0 [PES];
  logic [ACCW-1:0] copy1 [PES];
  logic [ACCW-1:0] copyNow [PES];
  logic [PES-1:0]  doneVec;

  for (genvar k = 0; k < PES; k++) begin : g_pe
    // Column skew: row k's matrix element is delayed k+1 periods, matching xStage[k].
    logic [W-1:0] aLine [0:k];
    always_ff @(posedge clk) begin
      if (strb.shift) begin
        aLine[0] <= inCol[k*W +: W];
        for (int d = 1; d <= k; d++) aLine[d] <= aLine[d-1];
      end
    end

    logic [2*W-1:0]  prod;
    logic [ACCW-1:0] term;
    logic [ACCW-1:0] base;
    logic [ACCW-1:0] accNext;
    logic [ACCW-1:0] acc0, acc1, acc2;

    assign prod = aLine[k] * xStage[k];

    always_comb begin
      term = ACCW'(prod);
      if (faultRows[k] && (hitCopy != 3'b000)) term = term ^ (faultMask << strb.phase);
      case (strb.phase)
        2'd0:    base = acc0;
        2'd1:    base = acc1;
        default: base = acc2;
      endcase
      if (firstStage[k]) base = '0;
      accNext = base + term;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        acc0 <= '0;
        acc1 <= '0;
        acc2 <= '0;
      end else if (valStage[k]) begin
        case (strb.phase)
          2'd0:    acc0 <= accNext;
          2'd1:    acc1 <= accNext;
          default: acc2 <= accNext;
        endcase
      end
    end

    assign copy0[k]   = acc0;
    assign copy1[k]   = acc1;
    assign copyNow[k] = accNext;
    assign doneVec[k] = valStage[k] && lastStage[k] && (strb.phase == PH_COPY2);
  end

  // Shared voter: at most one row finishes per period.
  logic            anyDone;
  logic [PEW-1:0]  selIdx;
  logic [ACCW-1:0] v0, v1, v2;
  logic [ACCW-1:0] voted;
  logic            noMajority;

  always_comb begin
    anyDone = 1'b0;
    selIdx  = '0;
    v0      = '0;
    v1      = '0;
    v2      = '0;
    for (int k = 0; k < PES; k++) begin
      if (doneVec[k]) begin
        anyDone = 1'b1;
        selIdx  = PEW'(k);
        v0      = copy0[k];
        v1      = copy1[k];
        v2      = copyNow[k];
      end
    end
    noMajority = 1'b0;
    if ((v0 == v1) || (v0 == v2)) begin
      voted = v0;
    end else if (v1 == v2) begin
      voted = v1;
    end else begin
      voted      = v0;
      noMajority = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid  <= 1'b0;
      resIdx    <= '0;
      resData   <= '0;
      resUncorr <= 1'b0;
    end else begin
      resValid  <= anyDone;
      resUncorr <= anyDone && noMajority;
      if (anyDone) begin
        resIdx  <= selIdx;
        resData <= voted;
      end
    end
  end

endmodule

// File: rtl/tmr_systolic_mv.sv
module tmr_systolic_mv
  import tmr_mv_pkg::*;
#(
  parameter int PES  = 4,
  parameter int COLS = 6,
  parameter int W    = 8,
  parameter int ACCW = 20,
  localparam int PEW = (PES > 1) ? $clog2(PES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [W-1:0]      inVec,
  input  logic [PES*W-1:0]  inCol,
  input  logic              faultEn,
  input  logic [PES-1:0]    faultRows,
  input  logic [2:0]        faultCopies,
  input  logic [ACCW-1:0]   faultMask,
  output logic              resValid,
  output logic [PEW-1:0]    resIdx,
  output logic [ACCW-1:0]   resData,
  output logic              resUncorr
);

  // Jobs must be at least as long as the chain so that finishing rows never collide.
  initial begin
    if (COLS < PES || ACCW < 2 * W) $error("tmr_systolic_mv: needs COLS >= PES and ACCW >= 2*W");
  end

  tmr_strobe_t strb;

  tmr_mv_ctrl #(.COLS(COLS)) ctrlI (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inReady (inReady),
    .strb    (strb)
  );

  tmr_mv_datapath #(.PES(PES), .W(W), .ACCW(ACCW)) dpI (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .inVec       (inVec),
    .inCol       (inCol),
    .faultEn     (faultEn),
    .faultRows   (faultRows),
    .faultCopies (faultCopies),
    .faultMask   (faultMask),
    .resValid    (resValid),
    .resIdx      (resIdx),
    .resData     (resData),
    .resUncorr   (resUncorr)
  );

endmodule

// File: rtl/tmr_systolic_mv_chk.sv
module tmr_systolic_mv_chk #(
  parameter int PES = 4,
  localparam int PEW = (PES > 1) ? $clog2(PES) : 1
) (
  input logic           clk,
  input logic           rstN,
  input logic           inReady,
  input logic           resValid,
  input logic [PEW-1:0] resIdx,
  input logic           resUncorr
);

  // R2
  slot_gap1_chk: assert property (@(posedge clk) disable iff (!rstN) inReady |=> !inReady);
  // R2
  slot_gap2_chk: assert property (@(posedge clk) disable iff (!rstN) inReady |=> ##1 !inReady);
  // R2
  slot_period_chk: assert property (@(posedge clk) disable iff (!rstN) inReady |=> ##2 inReady);
  // R4
  result_after_slot_chk: assert property (@(posedge clk) disable iff (!rstN) resValid |-> $past(inReady));
  // R4
  result_single_chk: assert property (@(posedge clk) disable iff (!rstN) resValid |=> !resValid);
  // R4
  result_row_range_chk: assert property (@(posedge clk) disable iff (!rstN) resValid |-> (int'(resIdx) < PES));
  // R7
  uncorr_with_valid_chk: assert property (@(posedge clk) disable iff (!rstN) resUncorr |-> resValid);

endmodule

bind tmr_systolic_mv tmr_systolic_mv_chk #(.PES(PES)) chkI (
  .clk       (clk),
  .rstN      (rstN),
  .inReady   (inReady),
  .resValid  (resValid),
  .resIdx    (resIdx),
  .resUncorr (resUncorr)
);

// File: tb/tmr_systolic_mv_test.sv
module tmr_systolic_mv_test;

  localparam int PES   = 4;
  localparam int COLS  = 6;
  localparam int W     = 8;
  localparam int ACCW  = 20;
  localparam int PEW   = (PES > 1) ? $clog2(PES) : 1;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG = 20000;

  logic              clk = 1'b0;
  logic              rstN;
  logic              inValid;
  logic              inReady;
  logic [W-1:0]      inVec;
  logic [PES*W-1:0]  inCol;
  logic              faultEn;
  logic [PES-1:0]    faultRows;
  logic [2:0]        faultCopies;
  logic [ACCW-1:0]   faultMask;
  logic              resValid;
  logic [PEW-1:0]    resIdx;
  logic [ACCW-1:0]   resData;
  logic              resUncorr;

  tmr_systolic_mv #(.PES(PES), .COLS(COLS), .W(W), .ACCW(ACCW)) uut (.*);

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit running = 1'b0;
  bit finished = 1'b0;

  typedef struct {
    int              when;
    int              row;
    logic [ACCW-1:0] data;
    bit              uncorr;
    string           tag;
  } expect_t;

  expect_t expq[$];

  int aM [PES][COLS];
  int xV [COLS];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Majority rule of R5 and R7.
  function automatic void vote(input logic [ACCW-1:0] c0, input logic [ACCW-1:0] c1,
                               input logic [ACCW-1:0] c2, output logic [ACCW-1:0] v,
                               output bit u);
    u = 1'b0;
    if (c0 == c1 || c0 == c2) v = c0;
    else if (c1 == c2) v = c1;
    else begin v = c0; u = 1'b1; end
  endfunction

  // Per-clock comparison against the expected result stream (R4 timing and order).
  always @(negedge clk) begin
    if (running) begin
      if (expq.size() > 0 && expq[0].when == cyc) begin
        check(resValid === 1'b1, expq[0].tag, "resValid", longint'(resValid), 1);
        check(int'(resIdx) == expq[0].row, "R4", "resIdx", longint'(resIdx), expq[0].row);
        check(resData === expq[0].data, expq[0].tag, "resData", longint'(resData), longint'(expq[0].data));
        check(resUncorr === expq[0].uncorr, expq[0].tag, "resUncorr", longint'(resUncorr), longint'(expq[0].uncorr));
        void'(expq.pop_front());
      end else begin
        check(resValid === 1'b0, "R4", "resValid outside expected cycle", longint'(resValid), 0);
      end
    end
  end

  // R2: ready slots are three cycles apart.
  int lastReady = -1;
  always @(negedge clk) begin
    if (running && inReady) begin
      if (lastReady >= 0) check(cyc - lastReady == 3, "R2", "ready spacing", cyc - lastReady, 3);
      lastReady = cyc;
    end
  end

  task automatic fillRandom(input int maxVal);
    for (int j = 0; j < COLS; j++) begin
      xV[j] = $urandom_range(maxVal);
      for (int k = 0; k < PES; k++) aM[k][j] = $urandom_range(maxVal);
    end
  endtask

  task automatic runJob(input string tag, input bit junk, input bit fEn,
                        input logic [PES-1:0] fRows, input logic [2:0] fCop,
                        input logic [ACCW-1:0] fMask, input bit drain);
    logic [ACCW-1:0] cp [3];
    logic [ACCW-1:0] v;
    logic [ACCW-1:0] p;
    bit              u;
    int              lastEdge;
    lastEdge = 0;
    for (int j = 0; j < COLS; j++) begin
      @(negedge clk);
      if (j == 0) begin
        faultEn     = fEn;
        faultRows   = fRows;
        faultCopies = fCop;
        faultMask   = fMask;
      end
      while (!inReady) begin
        inValid = junk;
        inVec   = W'($urandom);
        inCol   = {PES{W'($urandom)}};
        @(negedge clk);
      end
      inValid = 1'b1;
      inVec   = W'(xV[j]);
      for (int k = 0; k < PES; k++) inCol[k*W +: W] = W'(aM[k][j]);
      if (j == COLS - 1) lastEdge = cyc + 1;
    end
    // Expected copies per R3 and R11, then the vote.
    for (int k = 0; k < PES; k++) begin
      for (int c = 0; c < 3; c++) begin
        cp[c] = '0;
        for (int j = 0; j < COLS; j++) begin
          p = ACCW'(aM[k][j] * xV[j]);
          if (fEn && fRows[k] && fCop[c]) p = p ^ (fMask << c);
          cp[c] = cp[c] + p;
        end
      end
      vote(cp[0], cp[1], cp[2], v, u);
      expq.push_back('{when: lastEdge + 3 * k + 3, row: k, data: v, uncorr: u, tag: tag});
    end
    if (drain) begin
      @(negedge clk);
      inValid = 1'b0;
      while (expq.size() > 0) @(negedge clk);
      faultEn     = 1'b0;
      faultRows   = '0;
      faultCopies = '0;
      faultMask   = '0;
    end
  endtask

  initial begin
    for (int n = 0; n < WATCHDOG; n++) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected below %0d cycles", WATCHDOG, WATCHDOG);
    finishRun();
  end

  initial begin
    rstN        = 1'b0;
    inValid     = 1'b0;
    inVec       = '0;
    inCol       = '0;
    faultEn     = 1'b0;
    faultRows   = '0;
    faultCopies = '0;
    faultMask   = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(resValid === 1'b0, "R1", "resValid in reset", longint'(resValid), 0);
    check(inReady === 1'b0, "R1", "inReady in reset", longint'(inReady), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(resValid === 1'b0, "R1", "resValid after reset", longint'(resValid), 0);
    check(inReady === 1'b0, "R1", "inReady after reset", longint'(inReady), 0);
    running = 1'b1;

    // R3: small deterministic pattern
    for (int j = 0; j < COLS; j++) begin
      xV[j] = j + 1;
      for (int k = 0; k < PES; k++) aM[k][j] = k + j;
    end
    runJob("R3", 1'b0, 1'b0, '0, 3'b000, '0, 1'b1);

    // R3: full-scale operands
    for (int j = 0; j < COLS; j++) begin
      xV[j] = (1 << W) - 1;
      for (int k = 0; k < PES; k++) aM[k][j] = (1 << W) - 1;
    end
    runJob("R3", 1'b0, 1'b0, '0, 3'b000, '0, 1'b1);

    // R3: random jobs
    for (int t = 0; t < 4; t++) begin
      fillRandom((1 << W) - 1);
      runJob("R3", 1'b0, 1'b0, '0, 3'b000, '0, 1'b1);
    end

    // R8: off-slot inValid with junk data
    fillRandom((1 << W) - 1);
    runJob("R8", 1'b1, 1'b0, '0, 3'b000, '0, 1'b1);

    // R9: back-to-back jobs with no idle period, off-slot junk in between
    fillRandom((1 << W) - 1);
    runJob("R9", 1'b1, 1'b0, '0, 3'b000, '0, 1'b0);
    fillRandom((1 << W) - 1);
    runJob("R9", 1'b1, 1'b0, '0, 3'b000, '0, 1'b0);
    fillRandom((1 << W) - 1);
    runJob("R9", 1'b0, 1'b0, '0, 3'b000, '0, 1'b1);

    // R5: one copy corrupted on one row, each copy in turn
    for (int c = 0; c < 3; c++) begin
      fillRandom((1 << W) - 1);
      runJob("R5", 1'b0, 1'b1, PES'(1) << (c % PES), 3'b001 << c, ACCW'(37), 1'b1);
    end

    // R6: single-copy faults on every row at once
    fillRandom((1 << W) - 1);
    runJob("R6", 1'b1, 1'b1, '1, 3'b010, ACCW'(5), 1'b1);

    // R7, R11: two copies of a row corrupted, copies disagree
    fillRandom((1 << W) - 1);
    runJob("R7", 1'b0, 1'b1, PES'(2), 3'b011, ACCW'(1), 1'b1);
    fillRandom((1 << W) - 1);
    runJob("R11", 1'b0, 1'b1, PES'(9), 3'b110, ACCW'(3), 1'b1);

    // R10: selections set but faultEn low
    fillRandom((1 << W) - 1);
    runJob("R10", 1'b0, 1'b0, '1, 3'b111, ACCW'(255), 1'b1);

    repeat (6) @(negedge clk);
    check(expq.size() == 0, "R4", "results outstanding", expq.size(), 0);
    finishRun();
  end

endmodule